// File: doc/BRIEF.md
# Datapath BIST Signature Controller

This block runs a built-in self-test over the digital datapath of a two-channel, 8-bit converter. A write to the control register starts a run. For a fixed number of sample cycles the block replaces the converter samples at the head of both channel datapaths with pseudorandom words. Channel A gets the raw word and channel B gets its bitwise inverse. The injected words pass through the datapath unchanged in path, and they stay visible at its outputs.

At the datapath tail, every valid pair of returned words is folded into a CRC-16 signature. When the last expected pair arrives, the signature is compared with a constant given as a parameter. The result is latched into a read-only pass bit, and the run-enable bit clears itself.

A run can reseed the pseudorandom source, or it can let the source continue from the state where the previous run stopped. The continuing form produces a signature that is not meant to match the constant, so a test that uses it has to check the output words directly.

Top module: `dp_bist_ctrl`

## Requirements
- R1: After reset, the control register at 0x0E reads 0, the status register at 0x0F reads 0, `busy_o` and `pass_o` are 0, `inj_sel_o` is 0, and both injection words are 0.
- R2: A write to address 0x0E while idle stores bit 2 as the reseed flag. If bit 0 of the written value is 1, a run starts and control bit 0 reads 1 until the run ends. A start with bit 2 set loads the generator with all ones.
- R3: During a run, `inj_sel_o` is high for exactly RUN_LEN (512) consecutive cycles. Each of these cycles advances a 9-bit Fibonacci LFSR by 8 steps, where each step shifts left and takes s[8]^s[4] into bit 0. The channel A word is the low 8 bits of the advanced state.
- R4: On every injection cycle, the channel B word is the bitwise inverse of the channel A word.
- R5: The signature restarts at 0xFFFF when a run starts. On each cycle where `ret_valid_i` is high during a run, it is updated MSB-first with polynomial 0x1021, first with `ret_a_i` and then with `ret_b_i`. Cycles with `ret_valid_i` low are ignored, and so are returns that arrive while idle.
- R6: A run completes on its 512th valid return. On the next cycle, `busy_o` and control bit 0 read 0 and `inj_sel_o` stays low.
- R7: At completion, `pass_o` is set to 1 if the final signature equals `EXP_SIG` and to 0 otherwise. At no other time does `pass_o` change.
- R8: A start with bit 2 clear continues the LFSR from the state where the last run stopped. Its final signature is not expected to match, so the run reports fail.
- R9: Writes to the control register while busy are ignored: the run goes on, and control bit 0 still reads 1.
- R10: The status register at 0x0F reads the pass bit in bit 0 and busy in bit 1. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| inj_sel_o | output | 1 | Injection select: the words below replace the converter samples |
| inj_a_o | output | 8 | Injected word, channel A |
| inj_b_o | output | 8 | Injected word, channel B |
| ret_valid_i | input | 1 | Datapath return valid |
| ret_a_i | input | 8 | Datapath return, channel A |
| ret_b_i | input | 8 | Datapath return, channel B |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Result of the last completed run |

## Verification
The bench puts the datapath model behind the block with a variable delay, and on one run it holds the return valid low on every third cycle while driving junk data. A block that folded invalid cycles into the signature would report fail on a run that should pass. The bench also drives valid junk returns while the block is idle. A design that counted or compacted these returns would end the next run early or corrupt its signature.

A continuing run is compared word by word against the model's continued LFSR. A design that always reseeded would repeat the first run's words and report pass, and both mistakes show up. The bench writes the control register in the middle of a run and watches `pass_o` throughout. This catches a run that can be cancelled, and a result bit that changes before the run completes.

// File: rtl/dp_bist_pkg.sv
package dp_bist_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SIG_W    = 16;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 8'h0E;
  localparam logic [ADDR_W-1:0] STS_ADDR = 8'h0F;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_INIT_BIT = 2;
  localparam int unsigned STS_PASS_BIT = 0;
  localparam int unsigned STS_BUSY_BIT = 1;

  // MSB-first CRC update over one data word
  function automatic logic [SIG_W-1:0] crc_word(input logic [SIG_W-1:0] c,
                                                input logic [DATA_W-1:0] d,
                                                input logic [SIG_W-1:0] poly);
    logic [SIG_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[SIG_W-1] ^ d[i];
      r  = {r[SIG_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/dp_bist_pn.sv
module dp_bist_pn #(
  parameter int unsigned LFSR_W = 9,
  parameter int unsigned TAP_HI = 9,
  parameter int unsigned TAP_LO = 5,
  parameter int unsigned STEPS  = 8,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0] state_q, state_adv;

  always_comb begin
    state_adv = state_q;
    for (int i = 0; i < STEPS; i++)
      state_adv = {state_adv[LFSR_W-2:0], state_adv[TAP_HI-1] ^ state_adv[TAP_LO-1]};
  end

  assign word_o = state_adv[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (step_i) state_q <= state_adv;
  end
endmodule

// File: rtl/dp_bist_crc.sv
module dp_bist_crc
  import dp_bist_pkg::*;
#(
  parameter int unsigned      N_CH = 2,
  parameter logic [SIG_W-1:0] POLY = 16'h1021,
  parameter logic [SIG_W-1:0] INIT = 16'hFFFF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          upd_i,
  input  logic [N_CH-1:0][DATA_W-1:0]   data_i,
  output logic [SIG_W-1:0]              sig_next_o
);
  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] chain [N_CH+1];

  assign chain[0] = sig_q;
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign chain[g+1] = crc_word(chain[g], data_i[g], POLY);
  end
  assign sig_next_o = chain[N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= INIT;
    else if (clear_i) sig_q <= INIT;
    else if (upd_i)   sig_q <= sig_next_o;
  end
endmodule

// File: rtl/dp_bist_cnt.sv
module dp_bist_cnt #(
  parameter int unsigned LIMIT = 512,
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dp_bist_ctrl.sv
module dp_bist_ctrl
  import dp_bist_pkg::*;
#(
  parameter int unsigned      RUN_LEN = 512,
  parameter logic [SIG_W-1:0] EXP_SIG = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              inj_sel_o,
  output logic [DATA_W-1:0] inj_a_o,
  output logic [DATA_W-1:0] inj_b_o,
  input  logic              ret_valid_i,
  input  logic [DATA_W-1:0] ret_a_i,
  input  logic [DATA_W-1:0] ret_b_i,
  output logic              busy_o,
  output logic              pass_o
);
  localparam int unsigned N_CH = 2;

  logic en_q, init_q, inj_q, pass_q;
  logic ctl_wr, start, inj_last, ret_last, ret_take, done;
  logic [DATA_W-1:0] pn_word;
  logic [SIG_W-1:0]  sig_next;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_wdata = reg_wdata_i;

  // control writes land only while idle
  assign ctl_wr   = reg_we_i && (reg_addr_i == CTL_ADDR) && !en_q;
  assign start    = ctl_wr && reg_wdata_i[CTL_EN_BIT];
  assign ret_take = en_q && ret_valid_i;
  assign done     = ret_take && ret_last;

  dp_bist_pn #(.LFSR_W(9), .TAP_HI(9), .TAP_LO(5), .STEPS(DATA_W), .WORD_W(DATA_W)) u_pn (
    .clk_i, .rst_ni,
    .load_i (start && reg_wdata_i[CTL_INIT_BIT]),
    .step_i (inj_q),
    .word_o (pn_word)
  );

  dp_bist_cnt #(.LIMIT(RUN_LEN)) u_inj_cnt (
    .clk_i, .rst_ni, .clear_i(start), .inc_i(inj_q), .last_o(inj_last)
  );

  dp_bist_cnt #(.LIMIT(RUN_LEN)) u_ret_cnt (
    .clk_i, .rst_ni, .clear_i(start), .inc_i(ret_take), .last_o(ret_last)
  );

  dp_bist_crc #(.N_CH(N_CH)) u_crc (
    .clk_i, .rst_ni,
    .clear_i    (start),
    .upd_i      (ret_take),
    .data_i     ({ret_b_i, ret_a_i}),
    .sig_next_o (sig_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      init_q <= 1'b0;
      inj_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (ctl_wr) init_q <= reg_wdata_i[CTL_INIT_BIT];
      if (start)                 inj_q <= 1'b1;
      else if (inj_q && inj_last) inj_q <= 1'b0;
      if (start)     en_q <= 1'b1;
      else if (done) en_q <= 1'b0;
      if (done) pass_q <= (sig_next == EXP_SIG);
    end
  end

  assign inj_sel_o = inj_q;
  assign inj_a_o   = inj_q ? pn_word  : '0;
  assign inj_b_o   = inj_q ? ~pn_word : '0;
  assign busy_o    = en_q;
  assign pass_o    = pass_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == CTL_ADDR) begin
      reg_rdata_o[CTL_EN_BIT]   = en_q;
      reg_rdata_o[CTL_INIT_BIT] = init_q;
    end else if (reg_addr_i == STS_ADDR) begin
      reg_rdata_o[STS_PASS_BIT] = pass_q;
      reg_rdata_o[STS_BUSY_BIT] = en_q;
    end
  end
endmodule

// File: rtl/dp_bist_chk.sv
module dp_bist_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       inj_sel_o,
  input logic [7:0] inj_a_o,
  input logic [7:0] inj_b_o,
  input logic       ret_valid_i,
  input logic       busy_o,
  input logic       pass_o
);
  assert_inj_in_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_sel_o |-> busy_o);

  assert_inv_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_sel_o |-> (inj_b_o == ~inj_a_o));

  assert_start_by_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i));

  assert_end_on_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ret_valid_i));

  assert_pass_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_o) |-> $fell(busy_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!inj_sel_o && inj_a_o == 8'h00));
endmodule

bind dp_bist_ctrl dp_bist_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .inj_sel_o, .inj_a_o, .inj_b_o,
  .ret_valid_i, .busy_o, .pass_o
);

// File: tb/dp_bist_ctrl_bench.sv
module dp_bist_ctrl_bench;
  localparam int RUN = 512;

  function automatic logic [8:0] m_adv(input logic [8:0] s);
    logic [8:0] t;
    t = s;
    repeat (8) t = {t[7:0], t[8] ^ t[4]};
    return t;
  endfunction

  function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_sig();
    logic [8:0]  s;
    logic [15:0] c;
    s = 9'h1FF;
    c = 16'hFFFF;
    for (int k = 0; k < RUN; k++) begin
      s = m_adv(s);
      c = m_crc(c, s[7:0]);
      c = m_crc(c, ~s[7:0]);
    end
    return c;
  endfunction

  localparam logic [15:0] REF_SIG = ref_sig();

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic       we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic       sel, busy, pass;
  logic [7:0] ia, ib;
  logic       rv = 0;
  logic [7:0] ra = 0, rb = 0;

  dp_bist_ctrl #(.RUN_LEN(RUN), .EXP_SIG(REF_SIG)) u_dp_bist_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .inj_sel_o(sel),
    .inj_a_o(ia), .inj_b_o(ib), .ret_valid_i(rv), .ret_a_i(ra),
    .ret_b_i(rb), .busy_o(busy), .pass_o(pass)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  logic [15:0] dp_q[$];
  logic [8:0]  mstate = 9'h1FF;
  int  sel_cnt = 0;
  bit  gap_mode = 0, idle_junk = 0;
  int  cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor and datapath model
  always @(negedge clk) begin
    logic [15:0] w, e;
    cyc++;
    if (sel) begin
      sel_cnt++;
      w = {ia, ib};
      if (exp_q.size() == 0) check("R3 unexpected word", {16'h0, w}, 32'h0);
      else begin
        e = exp_q.pop_front();
        check("R3 chA word", {24'h0, ia}, {24'h0, e[15:8]});
        check("R4 chB word", {24'h0, ib}, {24'h0, e[7:0]});
      end
    end
    if (gap_mode && (cyc % 3 == 0)) begin
      rv = 0; ra = 8'hA5; rb = 8'h3C;
    end else if (dp_q.size() != 0) begin
      w = dp_q.pop_front();
      rv = 1; ra = w[15:8]; rb = w[7:0];
    end else if (idle_junk) begin
      rv = 1; ra = cyc[7:0]; rb = ~cyc[7:0] ^ 8'h11;
    end else begin
      rv = 0; ra = 0; rb = 0;
    end
    if (sel) dp_q.push_back({ia, ib});
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // driver: pushes expected words, returns expected pass
  task automatic start_run(input logic [7:0] cmd, output logic exp_pass);
    logic [15:0] c;
    if (cmd[2]) mstate = 9'h1FF;
    c = 16'hFFFF;
    for (int k = 0; k < RUN; k++) begin
      mstate = m_adv(mstate);
      exp_q.push_back({mstate[7:0], ~mstate[7:0]});
      c = m_crc(c, mstate[7:0]);
      c = m_crc(c, ~mstate[7:0]);
    end
    exp_pass = (c == REF_SIG);
    sel_cnt = 0;
    wr(8'h0E, cmd);
  endtask

  task automatic wait_done();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    check("R6 run ends", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    logic [7:0] d;
    logic ep, prev_pass;
    repeat (3) @(negedge clk);
    rd(8'h0E, d); check("R1 ctl reset", {24'h0, d}, 0);
    rd(8'h0F, d); check("R1 sts reset", {24'h0, d}, 0);
    check("R1 sel/busy/pass", {29'h0, sel, busy, pass}, 0);
    check("R1 inj words", {16'h0, ia, ib}, 0);
    rst_n = 1;
    @(negedge clk);

    // run 1: reseeded
    start_run(8'h05, ep);
    rd(8'h0E, d); check("R2 ctl during run", {24'h0, d}, 32'h05);
    repeat (100) @(negedge clk);
    rd(8'h0F, d); check("R10 sts busy mid-run", {24'h0, d}, 32'h02);
    check("R7 pass held mid-run", {31'h0, pass}, 0);
    wait_done();
    check("R3 run length", sel_cnt, RUN);
    check("R7 pass after reseeded run", {31'h0, pass}, {31'h0, ep});
    check("R7 reseeded run passes", {31'h0, ep}, 1);
    rd(8'h0E, d); check("R6 ctl en cleared", {31'h0, d[0]}, 0);
    rd(8'h0F, d); check("R10 sts pass", {24'h0, d}, 32'h01);
    rd(8'h20, d); check("R10 other addr", {24'h0, d}, 0);
    repeat (5) @(negedge clk);
    check("R6 sel low after run", {31'h0, sel}, 0);

    // run 2: continue
    start_run(8'h01, ep);
    rd(8'h0E, d); check("R2 ctl init clear", {24'h0, d}, 32'h01);
    repeat (50) @(negedge clk);
    check("R7 pass held in run 2", {31'h0, pass}, 1);
    wait_done();
    check("R3 run 2 length", sel_cnt, RUN);
    check("R8 continue run fails", {31'h0, pass}, {31'h0, ep});
    check("R8 model expects fail", {31'h0, ep}, 0);

    // junk returns while idle
    idle_junk = 1;
    repeat (40) @(negedge clk);
    idle_junk = 0;
    check("R5 idle returns ignored busy", {30'h0, busy, pass}, 0);

    // run 3: reseeded, gapped returns, write while busy
    gap_mode = 1;
    prev_pass = pass;
    start_run(8'h05, ep);
    repeat (60) @(negedge clk);
    wr(8'h0E, 8'h00);
    rd(8'h0E, d); check("R9 write while busy ignored", {24'h0, d}, 32'h05);
    check("R9 busy stays", {31'h0, busy}, 1);
    check("R7 pass held run 3", {31'h0, pass}, {31'h0, prev_pass});
    wait_done();
    gap_mode = 0;
    check("R3 run 3 length", sel_cnt, RUN);
    check("R5 gapped run passes", {31'h0, pass}, {31'h0, ep});
    check("R5 queue drained", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule